// File: doc/BRIEF.md
# Streaming Cross-Stencil Filter with Row Buffers

This block applies a radius-3 star-shaped finite-difference operator to a two-dimensional grid that arrives as a stream, one sample per accepted cycle, in row-major order. Each result combines thirteen inputs: the centre, plus the three nearest samples on each side of it in the same row and in the same column. The weights are symmetric. One weight applies to the centre. Each of three further weights applies to the four neighbours at distance one, two or three.

Six complete rows sit in on-chip row memories, so the samples above the centre are available the moment the newest row delivers the samples below it. The horizontal taps come from a short shift register. The arithmetic is signed fixed point. It uses a wide accumulator, rounds to nearest with halves going up, and saturates the result back to 16 bits. Centres closer than three samples to any border produce no output. A start-of-frame flag, given with the first sample of a frame, restarts the grid position counters.

Top module: `cross_stencil_engine`

## Requirements
- R1: While `rst_n` is low, and after it is released, `out_valid` is 0 until a full window has been streamed in; reset returns all four weights to zero, so every result is 0 until weights are written.
- R2: A result equals floor((c0*x(r,c) + sum over d=1..3 of cd*(x(r,c-d)+x(r,c+d)+x(r-d,c)+x(r+d,c)) + 2^(FRAC-1)) / 2^FRAC), where the samples and the weights are two's-complement 16-bit values.
- R3: A result above 32767 is output as 32767 and a result below -32768 as -32768.
- R4: A result is produced exactly once for each centre whose row lies in 3..ROW_CNT-4 and whose column lies in 3..ROW_LEN-4, and for no other centre; results appear in row-major order with `out_row`/`out_col` giving the centre.
- R5: The result for centre (r,c) appears on the outputs three clock edges after the edge that accepts input sample (r+3,c+3).
- R6: A cycle with `in_valid` low shifts no window and produces no result three cycles later; gaps in the stream do not change any result.
- R7: `in_sof` high together with `in_valid` makes that sample position (0,0), even in the middle of a row; no result follows until row 6, column 6 of the new frame has been accepted.
- R8: A write with `cfg_we` high stores `cfg_wdata` as the centre weight at `cfg_addr` 0, and as the distance-d weight at `cfg_addr` d (1..3); a weight changes only on a write.
- R9: A sample at (r,c) contributes only to results centred at most three positions away in the same row or the same column; the sample directly above in the grid is the one ROW_LEN samples earlier in the stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we | input | 1 | Weight write strobe |
| cfg_addr | input | 2 | Weight select: 0 centre, 1..3 neighbour distance |
| cfg_wdata | input | 16 | Signed weight value, FRAC fractional bits |
| in_valid | input | 1 | Input sample valid |
| in_sof | input | 1 | Marks the first sample of a frame |
| in_sample | input | 16 | Signed input sample |
| out_valid | output | 1 | Result valid |
| out_data | output | 16 | Signed rounded and saturated result |
| out_row | output | $clog2(ROW_CNT) | Grid row of the result centre |
| out_col | output | $clog2(ROW_LEN) | Grid column of the result centre |

## Verification
With identity weights on an irregular pattern, any misplaced tap or mis-timed row read shows up as a wrong value. A single nonzero sample under four distinct weights draws the cross itself. It shows whether each weight reaches the right distance, and whether diagonal positions stay at zero. Saturated constant and alternating-sign frames drive the accumulator to both clamps. A run with periodic idle cycles, a frame aborted in mid-row and a mid-stream reset test whether the window advances only on accepted samples, and whether a restart correctly restores the coordinates and the weights.

// File: rtl/cs_pkg.sv
package cs_pkg;
  localparam int RADIUS   = 3;
  localparam int SPAN     = 2 * RADIUS + 1;
  localparam int HELD     = 2 * RADIUS;
  localparam int SAMPLE_W = 16;
  localparam int COEF_W   = 16;
  localparam int SUM_W    = SAMPLE_W + 2;
  localparam int PIPE_LAT = 3;

  typedef enum logic [1:0] {
    WSEL_CENTRE = 2'd0,
    WSEL_DIST1  = 2'd1,
    WSEL_DIST2  = 2'd2,
    WSEL_DIST3  = 2'd3
  } wsel_e;
endpackage

// File: rtl/cs_line_buffer.sv
module cs_line_buffer #(
  parameter int ROW_LEN = 512,
  parameter int NROWS   = 6,
  parameter int W       = 16,
  localparam int PTR_W  = $clog2(ROW_LEN)
) (
  input  logic                    clk,
  input  logic                    en,
  input  logic [PTR_W-1:0]        ptr,
  input  logic [W-1:0]            din,
  output logic [NROWS:0][W-1:0]   taps
);
  // taps[k] is the sample k rows above the incoming one, same column
  assign taps[0] = din;

  for (genvar k = 0; k < NROWS; k++) begin : g_row
    logic [W-1:0] mem [ROW_LEN];

    assign taps[k+1] = mem[ptr];

    always_ff @(posedge clk) begin
      if (en) begin
        mem[ptr] <= taps[k];
      end
    end
  end
endmodule

// File: rtl/cs_window.sv
module cs_window #(
  parameter int W = 16,
  parameter int R = 3,
  localparam int TAPS  = 2 * R + 1,
  localparam int SUM_W = W + 2
) (
  input  logic                     clk,
  input  logic                     en,
  input  logic [TAPS-1:0][W-1:0]   taps,
  output logic [W-1:0]             centre,
  output logic [R-1:0][SUM_W-1:0]  sums
);
  // hist_q[k] holds the centre-row tap from k+1 accepted samples ago
  logic [2*R-1:0][W-1:0]    hist_q, hist_d;
  // vdly_q[R-1] is the full vertical column R samples ago (centre column)
  logic [R-1:0][TAPS*W-1:0] vdly_q, vdly_d;
  logic [TAPS-1:0][W-1:0]   vcol;

  always_comb begin
    hist_d = hist_q;
    vdly_d = vdly_q;
    if (en) begin
      hist_d = {hist_q[2*R-2:0], taps[R]};
      vdly_d = {vdly_q[R-2:0], taps};
    end
  end

  always_ff @(posedge clk) begin
    hist_q <= hist_d;
    vdly_q <= vdly_d;
  end

  assign vcol   = vdly_q[R-1];
  assign centre = hist_q[R-1];

  for (genvar d = 1; d <= R; d++) begin : g_ring
    logic [W-1:0] west, east, north, south;

    assign west  = hist_q[R+d-1];
    if (d == R) begin : g_east_live
      assign east = taps[R];
    end else begin : g_east_hist
      assign east = hist_q[R-d-1];
    end
    assign north = vcol[R+d];
    assign south = vcol[R-d];

    assign sums[d-1] = SUM_W'($signed(west))  + SUM_W'($signed(east))
                     + SUM_W'($signed(north)) + SUM_W'($signed(south));
  end
endmodule

// File: rtl/cs_mac.sv
module cs_mac #(
  parameter int W     = 16,
  parameter int CW    = 16,
  parameter int R     = 3,
  parameter int FRAC  = 8,
  parameter int ROW_W = 9,
  parameter int COL_W = 9,
  localparam int SUM_W  = W + 2,
  localparam int PROD_W = CW + SUM_W,
  localparam int ACC_W  = PROD_W + $clog2(R + 1) + 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_vld,
  input  logic [W-1:0]             centre,
  input  logic [R-1:0][SUM_W-1:0]  sums,
  input  logic [R:0][CW-1:0]       coef,
  input  logic [ROW_W-1:0]         in_row,
  input  logic [COL_W-1:0]         in_col,
  output logic                     out_vld,
  output logic [W-1:0]             out_data,
  output logic [ROW_W-1:0]         out_row,
  output logic [COL_W-1:0]         out_col
);
  localparam logic signed [ACC_W-1:0] RND_K  = ACC_W'(1) <<< (FRAC - 1);
  localparam logic signed [ACC_W-1:0] SAT_HI = ACC_W'((1 <<< (W - 1)) - 1);
  localparam logic signed [ACC_W-1:0] SAT_LO = -SAT_HI - ACC_W'(1);

  logic                     a_vld_q, b_vld_q, c_vld_q;
  logic [W-1:0]             a_ctr_q;
  logic [R-1:0][SUM_W-1:0]  a_sum_q;
  logic [ROW_W-1:0]         a_row_q, b_row_q, c_row_q;
  logic [COL_W-1:0]         a_col_q, b_col_q, c_col_q;
  logic signed [ACC_W-1:0]  b_acc_q, b_acc_d;
  logic signed [ACC_W-1:0]  rnd, shf;
  logic [W-1:0]             c_res_q, c_res_d;

  // stage B: weighted sum
  always_comb begin
    b_acc_d = ACC_W'($signed(coef[0])) * ACC_W'($signed(a_ctr_q));
    for (int d = 1; d <= R; d++) begin
      b_acc_d = b_acc_d + ACC_W'($signed(coef[d])) * ACC_W'($signed(a_sum_q[d-1]));
    end
  end

  // stage C: round half up, then clamp
  always_comb begin
    rnd = b_acc_q + RND_K;
    shf = rnd >>> FRAC;
    if (shf > SAT_HI) begin
      c_res_d = W'(SAT_HI);
    end else if (shf < SAT_LO) begin
      c_res_d = W'(SAT_LO);
    end else begin
      c_res_d = W'(shf);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_vld_q <= 1'b0;
      b_vld_q <= 1'b0;
      c_vld_q <= 1'b0;
    end else begin
      a_vld_q <= in_vld;
      b_vld_q <= a_vld_q;
      c_vld_q <= b_vld_q;
    end
  end

  always_ff @(posedge clk) begin
    if (in_vld) begin
      a_ctr_q <= centre;
      a_sum_q <= sums;
      a_row_q <= in_row;
      a_col_q <= in_col;
    end
    if (a_vld_q) begin
      b_acc_q <= b_acc_d;
      b_row_q <= a_row_q;
      b_col_q <= a_col_q;
    end
    if (b_vld_q) begin
      c_res_q <= c_res_d;
      c_row_q <= b_row_q;
      c_col_q <= b_col_q;
    end
  end

  assign out_vld  = c_vld_q;
  assign out_data = c_res_q;
  assign out_row  = c_row_q;
  assign out_col  = c_col_q;
endmodule

// File: rtl/cross_stencil_engine.sv
module cross_stencil_engine
  import cs_pkg::*;
#(
  parameter int ROW_LEN = 512,
  parameter int ROW_CNT = 512,
  parameter int FRAC    = 8,
  localparam int COL_W  = $clog2(ROW_LEN),
  localparam int ROW_W  = $clog2(ROW_CNT)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_we,
  input  logic [1:0]           cfg_addr,
  input  logic [15:0]          cfg_wdata,
  input  logic                 in_valid,
  input  logic                 in_sof,
  input  logic [15:0]          in_sample,
  output logic                 out_valid,
  output logic [15:0]          out_data,
  output logic [ROW_W-1:0]     out_row,
  output logic [COL_W-1:0]     out_col
);
  localparam logic [COL_W-1:0] LAST_COL = COL_W'(ROW_LEN - 1);
  localparam logic [ROW_W-1:0] LAST_ROW = ROW_W'(ROW_CNT - 1);
  localparam logic [COL_W-1:0] FIRST_COL_OUT = COL_W'(HELD);
  localparam logic [ROW_W-1:0] FIRST_ROW_OUT = ROW_W'(HELD);

  // reset synchronizer: asynchronous assert, synchronous release
  logic rst_meta_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  // grid position of the incoming sample
  logic [COL_W-1:0] col_q, col_d, cur_col, ctr_col;
  logic [ROW_W-1:0] row_q, row_d, cur_row, ctr_row;
  logic             win_vld;

  always_comb begin
    cur_col = in_sof ? '0 : col_q;
    cur_row = in_sof ? '0 : row_q;
    col_d   = col_q;
    row_d   = row_q;
    if (in_valid) begin
      row_d = cur_row;
      if (cur_col == LAST_COL) begin
        col_d = '0;
        row_d = (cur_row == LAST_ROW) ? cur_row : cur_row + ROW_W'(1);
      end else begin
        col_d = cur_col + COL_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      col_q <= '0;
      row_q <= '0;
    end else begin
      col_q <= col_d;
      row_q <= row_d;
    end
  end

  assign win_vld = in_valid && (cur_row >= FIRST_ROW_OUT) && (cur_col >= FIRST_COL_OUT);
  assign ctr_row = cur_row - ROW_W'(RADIUS);
  assign ctr_col = cur_col - COL_W'(RADIUS);

  // weights
  logic [RADIUS:0][COEF_W-1:0] coef_q, coef_d;

  always_comb begin
    coef_d = coef_q;
    if (cfg_we) begin
      unique case (wsel_e'(cfg_addr))
        WSEL_CENTRE: coef_d[0] = cfg_wdata;
        WSEL_DIST1:  coef_d[1] = cfg_wdata;
        WSEL_DIST2:  coef_d[2] = cfg_wdata;
        WSEL_DIST3:  coef_d[3] = cfg_wdata;
        default:     coef_d    = coef_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      coef_q <= '0;
    end else begin
      coef_q <= coef_d;
    end
  end

  // datapath
  logic [SPAN-1:0][SAMPLE_W-1:0]  taps;
  logic [SAMPLE_W-1:0]            centre;
  logic [RADIUS-1:0][SUM_W-1:0]   sums;

  cs_line_buffer #(
    .ROW_LEN (ROW_LEN),
    .NROWS   (HELD),
    .W       (SAMPLE_W)
  ) u_rows (
    .clk  (clk),
    .en   (in_valid),
    .ptr  (cur_col),
    .din  (in_sample),
    .taps (taps)
  );

  cs_window #(
    .W (SAMPLE_W),
    .R (RADIUS)
  ) u_window (
    .clk    (clk),
    .en     (in_valid),
    .taps   (taps),
    .centre (centre),
    .sums   (sums)
  );

  cs_mac #(
    .W     (SAMPLE_W),
    .CW    (COEF_W),
    .R     (RADIUS),
    .FRAC  (FRAC),
    .ROW_W (ROW_W),
    .COL_W (COL_W)
  ) u_mac (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .in_vld   (win_vld),
    .centre   (centre),
    .sums     (sums),
    .coef     (coef_q),
    .in_row   (ctr_row),
    .in_col   (ctr_col),
    .out_vld  (out_valid),
    .out_data (out_data),
    .out_row  (out_row),
    .out_col  (out_col)
  );
endmodule

// File: rtl/cross_stencil_checks.sv
module cross_stencil_checks #(
  parameter int ROW_LEN = 512,
  parameter int ROW_CNT = 512,
  localparam int COL_W  = $clog2(ROW_LEN),
  localparam int ROW_W  = $clog2(ROW_CNT)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_we,
  input logic              in_valid,
  input logic              in_sof,
  input logic              out_valid,
  input logic [ROW_W-1:0]  out_row,
  input logic [COL_W-1:0]  out_col,
  input logic [63:0]       coef_flat
);
  always @(negedge clk) begin
    if (!rst_n) begin
      p_reset_quiet_r1: assert (!out_valid);
    end
  end

  p_border_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_row >= ROW_W'(3)) && (out_row <= ROW_W'(ROW_CNT - 4))
               && (out_col >= COL_W'(3)) && (out_col <= COL_W'(ROW_LEN - 4)));

  p_row_order_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(out_valid) && out_row == $past(out_row))
      |-> out_col == $past(out_col) + COL_W'(1));

  p_latency_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid, 3));

  p_idle_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |-> ##3 !out_valid);

  p_sof_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_sof) |-> ##3 !out_valid);

  p_coef_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> $stable(coef_flat));
endmodule

bind cross_stencil_engine cross_stencil_checks #(
  .ROW_LEN (ROW_LEN),
  .ROW_CNT (ROW_CNT)
) u_checks (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg_we    (cfg_we),
  .in_valid  (in_valid),
  .in_sof    (in_sof),
  .out_valid (out_valid),
  .out_row   (out_row),
  .out_col   (out_col),
  .coef_flat (coef_q)
);

// File: tb/cross_stencil_engine_bench.sv
`timescale 1ns/1ps
module cross_stencil_engine_bench;
  localparam int COLS = 16;
  localparam int ROWS = 12;
  localparam int FRAC = 8;
  localparam int CW   = $clog2(COLS);
  localparam int RW   = $clog2(ROWS);

  typedef struct packed {
    logic               prog;
    logic signed [15:0] k0, k1, k2, k3;
    logic [2:0]         pat;
    logic               gap;
    logic [15:0]        cnt;
  } vec_t;

  // pattern 0 ramp, 1 irregular, 2 impulse, 3 all max, 4 all min, 5 alternating
  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 16'sd0,    16'sd0,   16'sd0,   16'sd0,   3'd0, 1'b0, 16'd60},
    '{1'b1, 16'sd256,  16'sd0,   16'sd0,   16'sd0,   3'd1, 1'b0, 16'd60},
    '{1'b1, -16'sd512, 16'sd64,  -16'sd32, 16'sd16,  3'd2, 1'b0, 16'd60},
    '{1'b1, 16'sd100,  16'sd30,  16'sd20,  16'sd10,  3'd1, 1'b1, 16'd60},
    '{1'b1, 16'sd256,  16'sd256, 16'sd256, 16'sd256, 3'd3, 1'b0, 16'd60},
    '{1'b1, 16'sd256,  16'sd256, 16'sd256, 16'sd256, 3'd4, 1'b1, 16'd60},
    '{1'b1, -16'sd300, 16'sd77,  -16'sd5,  16'sd3,   3'd5, 1'b0, 16'd60}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_we = 1'b0;
  logic [1:0]    cfg_addr = '0;
  logic [15:0]   cfg_wdata = '0;
  logic          in_valid = 1'b0;
  logic          in_sof = 1'b0;
  logic [15:0]   in_sample = '0;
  logic          out_valid;
  logic [15:0]   out_data;
  logic [RW-1:0] out_row;
  logic [CW-1:0] out_col;

  always #2.5 clk = ~clk;

  cross_stencil_engine #(.ROW_LEN(COLS), .ROW_CNT(ROWS), .FRAC(FRAC)) u_cross_stencil_engine (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .in_valid(in_valid), .in_sof(in_sof), .in_sample(in_sample),
    .out_valid(out_valid), .out_data(out_data), .out_row(out_row), .out_col(out_col));

  int    checks = 0;
  int    errors = 0;
  int    cyc = 0;
  int    img [ROWS][COLS];
  int    drv [ROWS][COLS];
  int    wt [4];
  int    er, ec, outs;
  string tag = "R1";

  always @(posedge clk) cyc <= cyc + 1;

  function automatic int pix(int pat, int r, int c);
    case (pat)
      0: return r * 100 + c * 7 - 500;
      1: return (((r * 37 + c * 91 + r * c * 13) % 4001) - 2000) * 8;
      2: return (r == 5 && c == 8) ? 1000 : 0;
      3: return 32767;
      4: return -32768;
      default: return ((r + c) % 2 == 1) ? 30000 : -30000;
    endcase
  endfunction

  function automatic int model(int r, int c);
    longint acc;
    acc = longint'(wt[0]) * img[r][c];
    for (int d = 1; d <= 3; d++)
      acc += longint'(wt[d]) * (img[r][c-d] + img[r][c+d] + img[r-d][c] + img[r+d][c]);
    acc = (acc + (64'sd1 <<< (FRAC - 1))) >>> FRAC;
    if (acc > 32767) acc = 32767;
    if (acc < -32768) acc = -32768;
    return int'(acc);
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // output monitor: order (R4), value (R2/R3 etc.), latency (R5)
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (er > ROWS - 4) begin
        check(0, "R4", "result beyond last centre", int'(out_row), ROWS - 4);
      end else begin
        check(int'(out_row) == er && int'(out_col) == ec, "R4", "centre coordinate",
              int'(out_row) * 1000 + int'(out_col), er * 1000 + ec);
        check(int'($signed(out_data)) == model(er, ec), tag, "result value",
              int'($signed(out_data)), model(er, ec));
        check(cyc - drv[er+3][ec+3] == 3, "R5", "latency", cyc - drv[er+3][ec+3], 3);
        outs++;
        ec++;
        if (ec > COLS - 4) begin
          ec = 3;
          er++;
        end
      end
    end
  end

  task automatic write_wt(int sel, int val);
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_addr = 2'(sel);
    cfg_wdata = 16'(val);
    wt[sel] = val;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic run_frame(int pat, bit gap, int nsamp);
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++)
        img[r][c] = pix(pat, r, c);
    er = 3; ec = 3; outs = 0;
    for (int i = 0; i < nsamp; i++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_sof = (i == 0);
      in_sample = 16'(img[i / COLS][i % COLS]);
      drv[i / COLS][i % COLS] = cyc;
      if (gap && (i % 3 == 2)) begin
        @(negedge clk);
        in_valid = 1'b0;
        in_sof = 1'b0;
      end
    end
    @(negedge clk);
    in_valid = 1'b0;
    in_sof = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R5 watchdog expired: actual %0d cycles expected completion", cyc);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++) wt[i] = 0;
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R1", "out_valid in reset", int'(out_valid), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(out_valid == 1'b0, "R1", "out_valid after reset", int'(out_valid), 0);

    // table walk
    for (int v = 0; v < NV; v++) begin
      case (v)
        0: tag = "R1";
        1: tag = "R2";
        2: tag = "R8 R9";
        3: tag = "R6";
        default: tag = "R3";
      endcase
      if (v == 6) tag = "R2 R3";
      if (VECS[v].prog) begin
        write_wt(0, int'(VECS[v].k0));
        write_wt(1, int'(VECS[v].k1));
        write_wt(2, int'(VECS[v].k2));
        write_wt(3, int'(VECS[v].k3));
      end
      run_frame(int'(VECS[v].pat), VECS[v].gap, ROWS * COLS);
      check(outs == int'(VECS[v].cnt), "R4", "results per frame", outs, int'(VECS[v].cnt));
    end

    // impulse: diagonal neighbour must stay zero (R9)
    tag = "R9";
    write_wt(0, 0); write_wt(1, 256); write_wt(2, 256); write_wt(3, 256);
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++)
        img[r][c] = pix(2, r, c);
    check(model(6, 9) == 0, "R9", "diagonal model sanity", model(6, 9), 0);
    run_frame(2, 1'b0, ROWS * COLS);
    check(outs == 60, "R9", "impulse frame results", outs, 60);

    // abort mid-row, restart with a new frame (R7)
    tag = "R7";
    write_wt(0, 256); write_wt(1, 32); write_wt(2, -16); write_wt(3, 8);
    run_frame(5, 1'b0, 8 * COLS + 5);
    check(outs == 20, "R7", "results of aborted frame", outs, 20);
    run_frame(1, 1'b0, ROWS * COLS);
    check(outs == 60, "R7", "results after restart", outs, 60);

    // reset in mid-stream clears pipeline and weights (R1)
    tag = "R1";
    run_frame(1, 1'b0, 100);
    @(negedge clk);
    in_valid = 1'b1;
    in_sample = 16'sd1234;
    rst_n = 1'b0;
    #1;
    check(out_valid == 1'b0, "R1", "out_valid at mid-stream reset", int'(out_valid), 0);
    @(negedge clk);
    in_valid = 1'b0;
    for (int i = 0; i < 4; i++) wt[i] = 0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    run_frame(0, 1'b0, ROWS * COLS);
    check(outs == 60, "R1", "results after reset", outs, 60);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule